// File: doc/BRIEF.md
# Debounced External Event Down-Counter

This block is an 8-bit down counter that is clocked by pulses on an external event pin, not by an internal prescaled clock. The event pin first passes through a two-flop synchroniser. A software-set polarity bit then picks whether rising or falling transitions are counted. Each counted transition lowers the count by one. A counted transition that arrives while the count is zero reloads the count from the reload input and raises a one-cycle underflow pulse.

An optional noise rejector sits between the synchroniser and the edge detector. It watches a slow sampling tick, nominally 2,048 Hz, and accepts a new input level only on the second falling edge of that tick after the level changed. If the input goes back to its old level before that second edge, the pending change is dropped. Chatter shorter than one tick period therefore never reaches the counter, while pulses that stay high and low for two tick periods or longer are always counted. With the rejector bypassed, the synchronised level goes straight to the edge detector and the tick has no effect. A run bit gates counting, and any divider selection used in other modes has no meaning here.

Top module: `event_down_counter`

## Requirements
- R1: While reset is held (synchronous, active low) the count equals the reload input and the underflow output is 0. The filter state is cleared.
- R2: With polarity 0, a falling transition of the event input is counted and a rising transition is not.
- R3: With polarity 1, a rising transition of the event input is counted and a falling transition is not.
- R4: Each counted transition at a nonzero count lowers the count by exactly one. In bypass mode the count changes on the fourth rising clock edge after the input change.
- R5: A counted transition at count 0 loads the value on the reload input and drives underflow high for exactly one cycle, in the same cycle that the reload appears. Changing the reload input at any other time leaves the count unchanged.
- R6: While the run input is 0 the count holds, and transitions that occur in that time are never counted later.
- R7: With the noise rejector enabled, an input excursion shorter than one tick period is rejected and leaves the count unchanged.
- R8: With the noise rejector enabled, a new level is accepted only on the second falling (1 to 0) edge of the sampling tick after the change. A level held for at least two tick periods is counted, and no level change is accepted while the tick stands still.
- R9: With the noise rejector disabled, the sampling tick has no effect and transitions are counted with the tick held constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evtIn | input | 1 | Raw external event input, asynchronous |
| sampleTick | input | 1 | Sampling tick level, nominally 2,048 Hz, synchronous to clk |
| runEn | input | 1 | 1 lets counted transitions change the count |
| reloadVal | input | 8 | Value loaded at reset and on underflow |
| polarityRise | input | 1 | 0 counts falling transitions, 1 counts rising transitions |
| filterEn | input | 1 | 1 enables the noise rejector, 0 bypasses it |
| countOut | output | 8 | Current count |
| underflow | output | 1 | One-cycle pulse when the count reloads from zero |

## Verification
Two functions can land in the same cycle: the reload of a new count and the underflow pulse. Both must appear together on the clock edge that follows a counted transition at zero. The bench provokes this by running the count down past zero several times, once with the reload input changed while the count is still running. Its scoreboard pairs each expected count with an expected underflow bit. The monitor fails any sample where the new count arrives without the pulse, the pulse arrives without the new count, or the count changes while nothing is expected.

// File: rtl/edc_pkg.sv
package edc_pkg;

  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic decStb;     // counted transition at a nonzero count
    logic reloadStb;  // counted transition at zero
  } edc_strobe_t;

endpackage

// File: rtl/edc_control.sv
module edc_control
  import edc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_EDGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evtIn,
  input  logic        sampleTick,
  input  logic        runEn,
  input  logic        polarityRise,
  input  logic        filterEn,
  input  logic        atZero,
  output edc_strobe_t strb,
  output logic        evtLevel,
  output logic        tickFall
);

  localparam int QCNT_W = (QUAL_EDGES > 1) ? $clog2(QUAL_EDGES) : 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncOut;
  logic                   tickPrev;
  logic                   evtFilt;
  logic                   evtPrev;
  logic [QCNT_W-1:0]      qualCnt;
  logic                   edgeHit;

  // Synchroniser chain for the asynchronous event pin
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) syncChain[0] <= 1'b0;
          else        syncChain[0] <= evtIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) syncChain[gi] <= 1'b0;
          else        syncChain[gi] <= syncChain[gi-1];
        end
      end
    end
  endgenerate

  assign syncOut = syncChain[SYNC_STAGES-1];

  // Falling-edge detector for the sampling tick
  always_ff @(posedge clk) begin
    if (!rst_n) tickPrev <= 1'b0;
    else        tickPrev <= sampleTick;
  end

  assign tickFall = tickPrev & ~sampleTick;

  // Noise rejector: a level change must survive QUAL_EDGES tick falls
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evtFilt <= 1'b0;
      qualCnt <= '0;
    end else if (!filterEn) begin
      evtFilt <= syncOut;
      qualCnt <= '0;
    end else if (syncOut == evtFilt) begin
      qualCnt <= '0;
    end else if (tickFall) begin
      if (qualCnt == QCNT_W'(QUAL_EDGES - 1)) begin
        evtFilt <= syncOut;
        qualCnt <= '0;
      end else begin
        qualCnt <= qualCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) evtPrev <= 1'b0;
    else        evtPrev <= evtFilt;
  end

  assign evtLevel = evtFilt;
  assign edgeHit  = polarityRise ? (evtFilt & ~evtPrev) : (~evtFilt & evtPrev);

  always_comb begin
    strb.decStb    = edgeHit & runEn & ~atZero;
    strb.reloadStb = edgeHit & runEn & atZero;
  end

endmodule

// File: rtl/edc_datapath.sv
module edc_datapath
  import edc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] reloadVal,
  input  edc_strobe_t      strb,
  output logic             atZero,
  output logic [CNT_W-1:0] countOut,
  output logic             underflow
);

  logic [CNT_W-1:0] count;
  logic             ufPulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= reloadVal;
      ufPulse <= 1'b0;
    end else begin
      ufPulse <= strb.reloadStb;
      if (strb.reloadStb)   count <= reloadVal;
      else if (strb.decStb) count <= count - 1'b1;
    end
  end

  assign atZero    = (count == '0);
  assign countOut  = count;
  assign underflow = ufPulse;

endmodule

// File: rtl/event_down_counter.sv
module event_down_counter
  import edc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_EDGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evtIn,
  input  logic             sampleTick,
  input  logic             runEn,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             polarityRise,
  input  logic             filterEn,
  output logic [CNT_W-1:0] countOut,
  output logic             underflow
);

  edc_strobe_t strb;
  logic        atZero;
  logic        evtLevel;
  logic        tickFall;

  edc_control #(
    .SYNC_STAGES(SYNC_STAGES),
    .QUAL_EDGES (QUAL_EDGES)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .evtIn       (evtIn),
    .sampleTick  (sampleTick),
    .runEn       (runEn),
    .polarityRise(polarityRise),
    .filterEn    (filterEn),
    .atZero      (atZero),
    .strb        (strb),
    .evtLevel    (evtLevel),
    .tickFall    (tickFall)
  );

  edc_datapath #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .reloadVal(reloadVal),
    .strb     (strb),
    .atZero   (atZero),
    .countOut (countOut),
    .underflow(underflow)
  );

endmodule

// File: rtl/edc_checker.sv
module edc_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             runEn,
  input logic             filterEn,
  input logic [CNT_W-1:0] reloadVal,
  input logic [CNT_W-1:0] countOut,
  input logic             underflow,
  input logic             evtLevel,
  input logic             tickFall
);

  assert_step_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !underflow && (countOut != $past(countOut)))
      |-> (countOut == $past(countOut) - CNT_W'(1)));

  assert_reload_from_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && underflow)
      |-> (($past(countOut) == '0) && (countOut == $past(reloadVal))));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> !underflow);

  assert_freeze_when_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !runEn |=> $stable(countOut));

  assert_filter_waits_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (filterEn && !tickFall) |=> $stable(evtLevel));

endmodule

bind event_down_counter edc_checker #(.CNT_W(CNT_W)) u_edc_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .runEn    (runEn),
  .filterEn (filterEn),
  .reloadVal(reloadVal),
  .countOut (countOut),
  .underflow(underflow),
  .evtLevel (evtLevel),
  .tickFall (tickFall)
);

// File: tb/event_down_counter_bench.sv
module event_down_counter_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         evtIn = 1'b0;
  logic         sampleTick = 1'b0;
  logic         runEn = 1'b1;
  logic [W-1:0] reloadVal = 8'd3;
  logic         polarityRise = 1'b0;
  logic         filterEn = 1'b0;
  logic [W-1:0] countOut;
  logic         underflow;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit monEn = 0;
  bit tickRun = 1;
  int expCnt;
  logic [W:0] expQ[$];   // {underflow, count}

  always #10 clk = ~clk;  // 50 MHz

  event_down_counter u_event_down_counter (
    .clk(clk), .rst_n(rst_n), .evtIn(evtIn), .sampleTick(sampleTick),
    .runEn(runEn), .reloadVal(reloadVal), .polarityRise(polarityRise),
    .filterEn(filterEn), .countOut(countOut), .underflow(underflow)
  );

  // Sampling tick: period 16 clocks, scaled-down stand-in for 2,048 Hz
  initial begin
    forever begin
      repeat (8) @(negedge clk);
      if (tickRun) sampleTick = ~sampleTick;
    end
  end

  task automatic checkNow(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Model of one counted transition, pushed to the scoreboard
  task automatic expectEdge();
    if (expCnt == 0) begin
      expCnt = int'(reloadVal);
      expQ.push_back({1'b1, W'(expCnt)});
    end else begin
      expCnt--;
      expQ.push_back({1'b0, W'(expCnt)});
    end
  endtask

  task automatic drivePulse(int hiW, int loW, bit counts);
    evtIn = 1'b1;
    if (counts && polarityRise) expectEdge();
    repeat (hiW) @(negedge clk);
    evtIn = 1'b0;
    if (counts && !polarityRise) expectEdge();
    repeat (loW) @(negedge clk);
  endtask

  // Monitor: pops an expected item whenever the count or underflow moves
  initial begin
    logic [W-1:0] lastCnt;
    logic [W:0]   item;
    lastCnt = '0;
    forever begin
      @(negedge clk);
      if (!monEn) begin
        lastCnt = countOut;
      end else if (countOut != lastCnt || underflow) begin
        checks++;
        if (expQ.size() == 0) begin
          failures++;
          $display("FAIL R2/R3 spurious change actual=%0d/%0b expected=no change",
                   countOut, underflow);
        end else begin
          item = expQ.pop_front();
          if ({underflow, countOut} != item) begin
            failures++;
            $display("FAIL %s actual=%0d/uf%0b expected=%0d/uf%0b",
                     item[W] ? "R5" : "R4", countOut, underflow, item[W-1:0], item[W]);
          end
        end
        lastCnt = countOut;
      end
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    checkNow("R1 count at reset", int'(countOut), 3);
    checkNow("R1 underflow at reset", int'(underflow), 0);
    rst_n = 1'b1;
    expCnt = 3;
    repeat (4) @(negedge clk);
    checkNow("R1 count after release", int'(countOut), 3);
    monEn = 1;

    // R2, R4, R5: falling polarity, bypass, through zero twice
    for (int i = 0; i < 5; i++) drivePulse(6, 8, 1);
    repeat (10) @(negedge clk);
    checkNow("R4 count after five falls", int'(countOut), expCnt);

    // R5: reload change takes effect only at underflow
    reloadVal = 8'd7;
    repeat (6) @(negedge clk);
    checkNow("R5 reload change no effect", int'(countOut), 2);
    for (int i = 0; i < 4; i++) drivePulse(6, 8, 1);
    repeat (10) @(negedge clk);
    checkNow("R5 reloaded new value", int'(countOut), 6);

    // R6: stopped counter ignores transitions
    runEn = 1'b0;
    for (int i = 0; i < 3; i++) drivePulse(6, 8, 0);
    repeat (10) @(negedge clk);
    checkNow("R6 frozen count", int'(countOut), expCnt);
    runEn = 1'b1;
    repeat (10) @(negedge clk);
    checkNow("R6 no late count", int'(countOut), expCnt);

    // R3: rising polarity
    polarityRise = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) drivePulse(6, 8, 1);
    repeat (10) @(negedge clk);
    checkNow("R3 rising count", int'(countOut), expCnt);

    // R9: bypass with tick frozen still counts
    tickRun = 0;
    for (int i = 0; i < 2; i++) drivePulse(6, 8, 1);
    repeat (10) @(negedge clk);
    checkNow("R9 bypass ignores tick", int'(countOut), expCnt);
    tickRun = 1;

    // R8: filtered, long pulses count
    polarityRise = 1'b0;
    filterEn = 1'b1;
    repeat (40) @(negedge clk);
    for (int i = 0; i < 3; i++) drivePulse(40, 40, 1);
    repeat (40) @(negedge clk);
    checkNow("R8 filtered long pulses", int'(countOut), expCnt);

    // R7: short glitches rejected
    for (int i = 0; i < 3; i++) drivePulse(5, 40, 0);
    repeat (40) @(negedge clk);
    checkNow("R7 glitches rejected", int'(countOut), expCnt);

    // R8: no acceptance while the tick stands still
    tickRun = 0;
    drivePulse(60, 60, 0);
    repeat (10) @(negedge clk);
    checkNow("R8 no tick no count", int'(countOut), expCnt);
    tickRun = 1;
    repeat (40) @(negedge clk);

    // R3 with rejector: rising polarity, long pulses through zero
    polarityRise = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 4; i++) drivePulse(40, 40, 1);
    repeat (60) @(negedge clk);
    checkNow("R3 filtered rising", int'(countOut), expCnt);
    checkNow("R4 scoreboard drained", expQ.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule